// File: doc/BRIEF.md
# Multi-Input Wakeup and Edge Interrupt Controller

This block watches a group of input pins (eight by default) for edges and turns them into two kinds of request for a processor core. The first is a wakeup request that brings the core out of a halt or idle state. The second is a single interrupt that all pins share. For each pin, software chooses whether a rising or a falling edge counts. The edge sets that pin's bit in a sticky pending register. A per-pin enable decides whether a pending bit may wake the core or interrupt it. The pending register is the only record of events, so there is no separate summary flag.

Software reaches the enable, edge-select and pending registers over a small bus with a write strobe and a combinational read. When the core wants to stop its clock it raises a halt request. The block grants it one cycle later, but only if no enabled bit is pending at that time. Wakeup does not depend on the interrupt enables. With the interrupt off, the core simply resumes after a wakeup. With it on, the interrupt request is raised as well.

Top module: `mwu_ctrl`

## Requirements
- R1: With edge-select bit 0, a low-to-high transition on a pin sets that pin's pending bit. The bit is set even when the pin's enable bit is 0.
- R2: With edge-select bit 1, a high-to-low transition on a pin sets that pin's pending bit. A pin that does not change sets nothing.
- R3: A pending bit stays set until software writes the pending register. A write loads the written value, so a 0 clears the bit and a 1 sets it.
- R4: The register address selects the register: address 0 is enable, 1 is edge select and 2 is pending. Each reads back what was last written, and address 3 reads as zero. All three registers are zero after reset, and so are all outputs.
- R5: wake_req is high exactly when some bit is both enabled and pending. It does not depend on gie or port_ie.
- R6: irq is high exactly when wake_req, gie and port_ie are all high.
- R7: halt_gnt is high in the cycle after a cycle in which halt_req was high and wake_req was low; otherwise it is low.
- R8: The block stores the previous pin sample with its polarity already applied. Inverting a pin's edge-select bit while the pin is static therefore counts as an edge and sets the pending bit.
- R9: When a software write to the pending register and a new edge on the same bit fall in the same cycle, the bit ends up set.
- R10: A pin change is visible in the pending register after SYNC_STAGES+1 rising clock edges, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Monitored pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 enable, 1 edge select, 2 pending |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data for bus_addr (combinational) |
| gie | input | 1 | Global interrupt enable |
| port_ie | input | 1 | Port interrupt enable |
| halt_req | input | 1 | Request to enter halt or idle |
| halt_gnt | output | 1 | Halt granted |
| wake_req | output | 1 | Wakeup request |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with its default parameters: N_PINS = 8 and SYNC_STAGES = 2. The two-flop synchronizer gives a fixed latency of three edges from a pin change to the pending bit. The race between a pending-register write and a fresh edge is timed against this latency to land in exactly the same cycle, and the pending value is also checked one cycle too early. With eight pins, mixed polarity patterns can be tested in which odd bits catch falling edges while even bits catch rising ones. The enable mask can also be set to differ from the pending mask, which shows that enable gates only wake_req and irq and not the setting of pending bits.

// File: rtl/mwu_pkg.sv
package mwu_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN   = 2'd0,
    REG_EDGE = 2'd1,
    REG_PEND = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mwu_sync.sv
module mwu_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      logic [W-1:0] stage_d [STAGES];

      always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
          stage_d[i] = stage_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) begin
            stage_q[i] <= '0;
          end
        end else begin
          for (int i = 0; i < STAGES; i++) begin
            stage_q[i] <= stage_d[i];
          end
        end
      end

      assign sync_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mwu_edge_det.sv
module mwu_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] falling_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] adj_now;
  logic [W-1:0] adj_prev_q;
  logic [W-1:0] adj_prev_d;

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      // polarity folded in before the compare: a falling pin looks rising
      assign adj_now[b] = level_i[b] ^ falling_i[b];
      assign hit_o[b]   = adj_now[b] & ~adj_prev_q[b];
    end
  endgenerate

  always_comb begin
    adj_prev_d = adj_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_prev_q <= '0;
    end else begin
      adj_prev_q <= adj_prev_d;
    end
  end
endmodule

// File: rtl/mwu_regs.sv
module mwu_regs
  import mwu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      hit_i,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      edge_o,
  output logic [W-1:0]      pend_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] edge_q, edge_d;
  logic [W-1:0] pend_q, pend_d;
  logic         en_ce, edge_ce, pend_ce;
  reg_sel_e     sel;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    en_ce   = wr_i && (sel == REG_EN);
    edge_ce = wr_i && (sel == REG_EDGE);
    pend_ce = (wr_i && (sel == REG_PEND)) || (|hit_i);
    en_d    = wdata_i;
    edge_d  = wdata_i;
    // a fresh edge is ORed after the write so it is never lost
    pend_d  = ((wr_i && (sel == REG_PEND)) ? wdata_i : pend_q) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
      pend_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (edge_ce) edge_q <= edge_d;
      if (pend_ce) pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (sel)
      REG_EN:   rdata_o = en_q;
      REG_EDGE: rdata_o = edge_q;
      REG_PEND: rdata_o = pend_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign edge_o = edge_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/mwu_ctrl.sv
module mwu_ctrl
  import mwu_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic              gie,
  input  logic              port_ie,
  input  logic              halt_req,
  output logic              halt_gnt,
  output logic              wake_req,
  output logic              irq
);
  logic [N_PINS-1:0] pin_s;
  logic [N_PINS-1:0] hit;
  logic [N_PINS-1:0] en_q;
  logic [N_PINS-1:0] edge_q;
  logic [N_PINS-1:0] pend_q;
  logic              wake_any;
  logic              gnt_q, gnt_d;

  mwu_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_s)
  );

  mwu_edge_det #(.W(N_PINS)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (pin_s),
    .falling_i (edge_q),
    .hit_o     (hit)
  );

  mwu_regs #(.W(N_PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .hit_i   (hit),
    .en_o    (en_q),
    .edge_o  (edge_q),
    .pend_o  (pend_q),
    .rdata_o (bus_rdata)
  );

  assign wake_any = |(en_q & pend_q);

  always_comb begin
    gnt_d = halt_req && !wake_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= 1'b0;
    end else begin
      gnt_q <= gnt_d;
    end
  end

  assign halt_gnt = gnt_q;
  assign wake_req = wake_any;
  assign irq      = wake_any & gie & port_ie;
endmodule

// File: rtl/mwu_ctrl_chk.sv
module mwu_ctrl_chk
  import mwu_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              gie,
  input logic              port_ie,
  input logic              halt_req,
  input logic              halt_gnt,
  input logic              wake_req,
  input logic              irq,
  input logic [N_PINS-1:0] pend_q
);
  logic pend_write;
  assign pend_write = bus_wr && (bus_addr == REG_PEND);

  // R6
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && port_ie && wake_req));

  // R5
  p_wake_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (pend_q != '0));

  // R7
  p_gnt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_gnt |-> ($past(halt_req) && !$past(wake_req)));

  // R7
  p_gnt_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && wake_req) |=> !halt_gnt);

  // R7
  p_gnt_given_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !wake_req) |=> halt_gnt);

  // R3
  p_pend_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pend_write) |-> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind mwu_ctrl mwu_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .gie      (gie),
  .port_ie  (port_ie),
  .halt_req (halt_req),
  .halt_gnt (halt_gnt),
  .wake_req (wake_req),
  .irq      (irq),
  .pend_q   (pend_q)
);

// File: tb/mwu_ctrl_bench.sv
module mwu_ctrl_bench;
  localparam int N     = 8;
  localparam int SYNC  = 2;
  localparam int NVEC  = 6;
  localparam logic [1:0] A_EN = 2'd0, A_EDGE = 2'd1, A_PEND = 2'd2, A_NONE = 2'd3;

  // {en, edge, before, after, gie, port_ie, expected pending}
  localparam logic [41:0] VEC [NVEC] = '{
    {8'hFF, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1, 8'hFF},
    {8'h0F, 8'h00, 8'h00, 8'hF0, 1'b1, 1'b1, 8'hF0},
    {8'hFF, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 8'hFF},
    {8'h55, 8'hAA, 8'hAA, 8'h55, 1'b0, 1'b1, 8'hFF},
    {8'h3C, 8'h0F, 8'h0F, 8'h0F, 1'b1, 1'b1, 8'h00},
    {8'h81, 8'h01, 8'h01, 8'h00, 1'b1, 1'b1, 8'h01}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic         bus_wr = 1'b0;
  logic [1:0]   bus_addr = 2'd0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         gie = 1'b0, port_ie = 1'b0, halt_req = 1'b0;
  logic         halt_gnt, wake_req, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mwu_ctrl #(.N_PINS(N), .SYNC_STAGES(SYNC)) u_mwu_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gie(gie), .port_ie(port_ie), .halt_req(halt_req),
    .halt_gnt(halt_gnt), .wake_req(wake_req), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [N-1:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v_en, v_edge, v_bef, v_aft, v_exp;
    logic       v_gie, v_pie, exp_wake;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    rd("R4 reset enable", A_EN, 8'h00);
    rd("R4 reset edge", A_EDGE, 8'h00);
    rd("R4 reset pending", A_PEND, 8'h00);
    chk("R4 reset outputs", {5'd0, halt_gnt, wake_req, irq}, 8'h00);

    // R4 readback
    wr(A_EN, 8'hA5);
    rd("R4 enable readback", A_EN, 8'hA5);
    wr(A_EDGE, 8'h3C);
    rd("R4 edge readback", A_EDGE, 8'h3C);
    rd("R4 unused address", A_NONE, 8'h00);
    wr(A_EN, 8'h00);
    settle();
    wr(A_PEND, 8'h00);

    // vector table: R1 R2 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      {v_en, v_edge, v_bef, v_aft, v_gie, v_pie, v_exp} = VEC[k];
      wr(A_EN, 8'h00);
      wr(A_EDGE, v_edge);
      pin_i = v_bef;
      settle();
      wr(A_PEND, 8'h00);
      wr(A_EN, v_en);
      gie = v_gie; port_ie = v_pie;
      pin_i = v_aft;
      settle();
      rd($sformatf("R1 R2 vector %0d pending", k), A_PEND, v_exp);
      exp_wake = |(v_en & v_exp);
      chk($sformatf("R5 vector %0d wake", k), {7'd0, wake_req}, {7'd0, exp_wake});
      chk($sformatf("R6 vector %0d irq", k), {7'd0, irq}, {7'd0, exp_wake & v_gie & v_pie});
    end
    gie = 1'b0; port_ie = 1'b0;

    // R3: pending sticky, write clears and sets
    wr(A_EN, 8'h00);
    wr(A_EDGE, 8'h00);
    pin_i = 8'h00;
    settle();
    wr(A_PEND, 8'h00);
    pin_i = 8'h10;
    settle();
    pin_i = 8'h00;
    settle();
    rd("R3 pending held after pin returns", A_PEND, 8'h10);
    wr(A_PEND, 8'h00);
    rd("R3 write clears", A_PEND, 8'h00);
    wr(A_PEND, 8'h42);
    rd("R3 write sets", A_PEND, 8'h42);
    wr(A_PEND, 8'h00);

    // R8: polarity flip on a static pin
    wr(A_EDGE, 8'h04);
    settle();
    rd("R8 polarity flip sets pending", A_PEND, 8'h04);
    wr(A_EDGE, 8'h00);
    settle();
    wr(A_PEND, 8'h02);

    // R9 + R10: clear racing a new edge
    @(negedge clk);
    pin_i = 8'h01;
    @(negedge clk);
    @(negedge clk);
    rd("R10 not yet visible", A_PEND, 8'h02);
    bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd("R9 edge wins over clear", A_PEND, 8'h01);
    wr(A_PEND, 8'h00);

    // R7: halt grant
    wr(A_EN, 8'hFF);
    @(negedge clk);
    halt_req = 1'b1;
    #1;
    chk("R7 no grant same cycle", {7'd0, halt_gnt}, 8'h00);
    @(negedge clk);
    chk("R7 grant next cycle", {7'd0, halt_gnt}, 8'h01);
    pin_i = 8'h09;
    settle();
    chk("R5 wake while halted", {7'd0, wake_req}, 8'h01);
    chk("R7 grant dropped on wake", {7'd0, halt_gnt}, 8'h00);
    chk("R6 no irq with enables low", {7'd0, irq}, 8'h00);
    wr(A_PEND, 8'h00);
    @(negedge clk);
    chk("R7 grant after clear", {7'd0, halt_gnt}, 8'h01);
    halt_req = 1'b0;
    @(negedge clk);
    chk("R7 grant released", {7'd0, halt_gnt}, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule